// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped cache that the fetch stage reads with the current fetch PC. In that same cycle it returns a predicted next PC. The fetch stage therefore knows where to go next before decode has shown that the instruction is a branch. Each slot holds three things: the upper bits of a branch address as a tag, the branch's last target and a one-bit direction. The direction bit is the outcome the branch had the last time it resolved.

A hit with the direction bit set sends fetch to the stored target. A miss, or a hit whose bit is clear, sends fetch to PC plus 4. A branch that misses and is not taken therefore costs nothing. The resolve stage reports each branch through an update port. A taken branch that missed is allocated and replaces whatever the slot held. A branch that hit has its entry corrected. An invalidate request drops a matching entry.

If the prediction the buffer would have made for the resolved branch differs from the real next PC, the block raises a redirect pulse in the cycle after the update. The pulse lasts one cycle and carries the correct next PC.

Top module: `btb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses.
- R2: A lookup that misses gives `pred_hit`=0, `pred_taken`=0 and `pred_next_pc` = `fetch_pc`+4, in the same cycle.
- R3: A lookup that hits an entry whose direction bit is 1 gives `pred_hit`=1, `pred_taken`=1 and `pred_next_pc` = the stored target, in the same cycle.
- R4: A lookup that hits an entry whose direction bit is 0 gives `pred_hit`=1, `pred_taken`=0 and `pred_next_pc` = `fetch_pc`+4.
- R5: The slot index is PC bits [IW+1:2] and the tag is PC bits [AW-1:IW+2], where IW = log2(ENTRIES). A PC that shares an index with a stored entry but has a different tag misses.
- R6: An update (`upd_valid`=1, `upd_inval`=0, `upd_taken`=1) that misses writes its slot with the new tag and target and sets the direction bit to 1. Any previous occupant of that slot is replaced.
- R7: An update with `upd_taken`=0 that misses changes no slot.
- R8: An update that hits sets the direction bit to `upd_taken`. When `upd_taken`=1 it also overwrites the target with `upd_target`.
- R9: In the cycle after an update, `mispredict` is 1 exactly when the next PC predicted from the old contents differs from the real next PC. The real next PC is `upd_target` if taken, otherwise `upd_pc`+4. `redirect_pc` then holds the real next PC. The pulse lasts one cycle per update.
- R10: An update with `upd_inval`=1 clears the slot only when its tag matches, and never raises `mispredict`.
- R11: When an update and a lookup reach the same slot in one cycle, the lookup sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | AW | PC being fetched |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Hit, and the entry predicts taken |
| pred_next_pc | output | AW | Predicted next fetch PC |
| upd_valid | input | 1 | Update request from the resolve stage |
| upd_inval | input | 1 | Update is an invalidate |
| upd_pc | input | AW | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | AW | Resolved target |
| mispredict | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | AW | Correct next PC while `mispredict` is 1 |

## Verification
Every lookup is combinational, so a wrong tag, target or direction bit shows up on `pred_next_pc` in the same cycle the affected PC is fetched. The tests fetch each PC right after the update that should have changed its slot. A wrong write therefore appears within one cycle. A write to the wrong slot shows up when the slot's previous occupant is fetched, or when an aliasing PC that should miss is fetched. An error in the update-side comparison shows up one cycle after the update, as a missing or extra `mispredict` pulse or a wrong `redirect_pc`.

// File: rtl/btb.sv
module btb #(
  parameter int AW      = 32,
  parameter int ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_pc,
  output logic          pred_hit,
  output logic          pred_taken,
  output logic [AW-1:0] pred_next_pc,
  input  logic          upd_valid,
  input  logic          upd_inval,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target,
  output logic          mispredict,
  output logic [AW-1:0] redirect_pc
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - IW - 2;

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] dir;
  logic [TW-1:0]      tag_mem [ENTRIES];
  logic [AW-1:0]      tgt_mem [ENTRIES];

  logic [IW-1:0] f_idx, u_idx;
  logic [TW-1:0] f_tag, u_tag;
  logic          u_hit, u_write;
  logic [AW-1:0] u_pred_next, u_act_next;

  assign f_idx = fetch_pc[IW+1:2];
  assign f_tag = fetch_pc[AW-1:IW+2];
  assign pred_hit     = vld[f_idx] && (tag_mem[f_idx] == f_tag);
  assign pred_taken   = pred_hit && dir[f_idx];
  assign pred_next_pc = pred_taken ? tgt_mem[f_idx] : fetch_pc + AW'(4);

  assign u_idx       = upd_pc[IW+1:2];
  assign u_tag       = upd_pc[AW-1:IW+2];
  assign u_hit       = vld[u_idx] && (tag_mem[u_idx] == u_tag);
  assign u_pred_next = (u_hit && dir[u_idx]) ? tgt_mem[u_idx] : upd_pc + AW'(4);
  assign u_act_next  = upd_taken ? upd_target : upd_pc + AW'(4);
  assign u_write     = upd_valid && !upd_inval && (u_hit || upd_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      dir <= '0;
    end else if (upd_valid && upd_inval) begin
      if (u_hit) vld[u_idx] <= 1'b0;
    end else if (u_write) begin
      vld[u_idx] <= 1'b1;
      dir[u_idx] <= upd_taken;
    end
  end

  always_ff @(posedge clk) begin
    if (u_write && upd_taken) begin
      tag_mem[u_idx] <= u_tag;
      tgt_mem[u_idx] <= upd_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= upd_valid && !upd_inval && (u_pred_next != u_act_next);
      redirect_pc <= u_act_next;
    end
  end
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_pc,
  input logic          pred_hit,
  input logic [AW-1:0] pred_next_pc,
  input logic          upd_valid,
  input logic          upd_inval,
  input logic [AW-1:0] upd_pc,
  input logic          upd_taken,
  input logic [AW-1:0] upd_target,
  input logic          mispredict,
  input logic [AW-1:0] redirect_pc
);
  // R9
  mispredict_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> $past(upd_valid && !upd_inval));

  // R9
  redirect_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> redirect_pc == $past(upd_taken ? upd_target : upd_pc + AW'(4)));

  // R10
  inval_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_valid && upd_inval) |-> !mispredict);

  // R6
  alloc_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid && !upd_inval && upd_taken) && fetch_pc == $past(upd_pc))
      |-> (pred_hit && pred_next_pc == $past(upd_target)));

  // R10
  inval_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid && upd_inval) && fetch_pc == $past(upd_pc)) |-> !pred_hit);
endmodule

bind btb btb_chk #(.AW(AW)) u_btb_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
  .pred_next_pc(pred_next_pc), .upd_valid(upd_valid), .upd_inval(upd_inval),
  .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
  .mispredict(mispredict), .redirect_pc(redirect_pc)
);

// File: tb/btb_bench.sv
module btb_bench;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic upd_valid = 0, upd_inval = 0, upd_taken = 0;
  logic pred_hit, pred_taken, mispredict;
  logic [AW-1:0] pred_next_pc, redirect_pc;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  btb #(.AW(AW), .ENTRIES(16)) u_btb (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .upd_valid(upd_valid),
    .upd_inval(upd_inval), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .mispredict(mispredict), .redirect_pc(redirect_pc));

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [AW-1:0] pc, logic hit, logic tk, logic [AW-1:0] nxt);
    fetch_pc = pc;
    #1;
    chk({req, " hit"}, AW'(pred_hit), AW'(hit));
    chk({req, " taken"}, AW'(pred_taken), AW'(tk));
    chk({req, " next"}, pred_next_pc, nxt);
  endtask

  task automatic upd(string req, logic [AW-1:0] pc, logic tk, logic [AW-1:0] tgt,
                     logic inv, logic mis, logic [AW-1:0] rd);
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_inval = inv;
    @(negedge clk);
    upd_valid = 0; upd_inval = 0;
    chk({req, " mispredict"}, AW'(mispredict), AW'(mis));
    if (mis) chk({req, " redirect"}, redirect_pc, rd);
  endtask

  task automatic t_reset;
    look("R1", 32'h100, 0, 0, 32'h104);
    look("R2", 32'h1000, 0, 0, 32'h1004);
    chk("R1 mispredict", AW'(mispredict), '0);
  endtask

  task automatic t_alloc;
    upd("R6", 32'h100, 1, 32'h200, 0, 1, 32'h200);
    look("R3", 32'h100, 1, 1, 32'h200);
    look("R5 alias", 32'h1100, 0, 0, 32'h1104);
    upd("R9 correct", 32'h100, 1, 32'h200, 0, 0, '0);
  endtask

  task automatic t_correct;
    upd("R8 to not-taken", 32'h100, 0, 32'h0, 0, 1, 32'h104);
    look("R4", 32'h100, 1, 0, 32'h104);
    upd("R8 new target", 32'h100, 1, 32'h300, 0, 1, 32'h300);
    look("R8", 32'h100, 1, 1, 32'h300);
  endtask

  task automatic t_no_alloc;
    upd("R7", 32'h144, 0, 32'h0, 0, 0, '0);
    look("R7", 32'h144, 0, 0, 32'h148);
  endtask

  task automatic t_replace;
    upd("R6 replace", 32'h1100, 1, 32'h500, 0, 1, 32'h500);
    look("R6 old gone", 32'h100, 0, 0, 32'h104);
    look("R6 new", 32'h1100, 1, 1, 32'h500);
  endtask

  task automatic t_inval;
    upd("R10 tag mismatch", 32'h100, 0, 32'h0, 1, 0, '0);
    look("R10 kept", 32'h1100, 1, 1, 32'h500);
    upd("R10 match", 32'h1100, 0, 32'h0, 1, 0, '0);
    look("R10 cleared", 32'h1100, 0, 0, 32'h1104);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_valid = 1; upd_pc = 32'h208; upd_taken = 1; upd_target = 32'h800; upd_inval = 0;
    look("R11 old contents", 32'h208, 0, 0, 32'h20C);
    @(negedge clk);
    upd_valid = 0;
    chk("R9 same-cycle mispredict", AW'(mispredict), 1);
    look("R11 after write", 32'h208, 1, 1, 32'h800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_alloc;
    t_correct;
    t_no_alloc;
    t_replace;
    t_inval;
    t_same_cycle;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule